// File: doc/BRIEF.md
# Paired-Stream Line Number and Payload ID Inserter

This block sits on the transmit side of a multi-stream serial digital video source that carries sixteen 10-bit elementary streams, arranged as eight pairs. Each stream is watched for its own end-of-active-video timing reference. When insertion is enabled, the block overwrites the two words that follow that reference with an encoded line number. The number comes from an 11-bit line input, and each such input serves one pair of streams. When payload identification is also enabled, the block writes a four-byte payload identifier ancillary packet into the horizontal blanking space of the odd stream of each pair. A second set of per-pair payload inputs can place a packet into the even stream of the pair as well.

All sixteen streams move together as one 160-bit word per transfer, using a valid/ready handshake at both edges. `in_ready` is high whenever the output register is empty or is being drained that cycle, so `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output word is held unchanged and no input is accepted. Each accepted word appears at the output one transfer later. This latency is the same whether insertion is on or off. The line, payload and control inputs are plain levels. The block captures them on the transfer that carries the timing reference's final word, so they need only be stable from that word until the start of the next active video.

Top module: `lnpid_inserter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` stay unchanged on the next cycle.
- R3: Every accepted input word appears on `out_data` exactly once, in order, one transfer later. When `ins_ln` is 0, every stream passes through unchanged.
- R4: Stream s occupies `in_data[10*s +: 10]`, with s = 0 as the first stream. An end-of-active-video reference is the word sequence 0x3FF, 0x000, 0x000 followed by a word with bit 6 set, all in one stream. A reference word with bit 6 clear, or a word with bit 6 set that lacks that preamble, changes nothing.
- R5: With `ins_ln` captured high, the two words that follow the reference word are replaced. For line value L, the first replacement is {~L[6], L[6:0], 2'b00} and the second is {1'b1, 3'b000, L[10:7], 2'b00}.
- R6: The line value for pair k is `ln_in[11*k +: 11]`, and it serves streams 2k and 2k+1.
- R7: Line and payload inputs are captured on the transfer of the reference word. Later changes have no effect on that line.
- R8: The third and fourth words after the reference word (the error-check words) pass through unchanged.
- R9: With `ins_ln` and `ins_pid` captured high, the words in positions 5 to 15 after the reference word in stream 2k are replaced by 0x000, 0x3FF, 0x3FF, 0x241, 0x101, 0x104 and then four user words. User word j is byte `pid_in[32*k + 8*j +: 8]` with bit 8 set to the byte's XOR parity and bit 9 set to the inverse of bit 8.
- R10: The packet's last word is a checksum. Its bits 8:0 hold the 9-bit sum of bits 8:0 of the words 0x241 through the last user word, and bit 9 is the inverse of bit 8.
- R11: With `ins_ln` captured low, `ins_pid` inserts nothing.
- R12: With `ins_ln`, `ins_pid` and `ins_x` captured high, stream 2k+1 also receives a packet in the same positions, built from `pidx_in[32*k +: 32]`. With `ins_x` low, stream 2k+1 is unchanged in those positions.
- R13: `ins_ln`, `ins_pid` and `ins_x` are captured per stream on the reference-word transfer. Changing them later in the line has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid (replaces the clock enable) |
| in_ready | output | 1 | Block can accept an input word |
| in_data | input | 160 | Sixteen 10-bit stream words |
| ln_in | input | 88 | Eight 11-bit line values, one per pair |
| pid_in | input | 256 | Eight 32-bit payload identifiers for the odd streams |
| pidx_in | input | 256 | Eight 32-bit payload identifiers for the extra (even) streams |
| ins_ln | input | 1 | Line number insertion enable |
| ins_pid | input | 1 | Payload packet insertion enable (needs ins_ln) |
| ins_x | input | 1 | Extra packet into the even stream of each pair |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 160 | Sixteen modified 10-bit stream words |

## Verification
Each line is sent with insertion off, with line numbers only, with packets only in the odd streams, with packets in both streams of each pair, and with packet enable but no line enable. Comparing these lines separates faults in the line encoding, the pair mapping, the packet contents, the checksum and the enable gating. Every line also carries a bare 0x274 word without a preamble and a start-of-active-video reference, so a detector that is too loose shows up as a corrupted word. Two lines change the line, payload and control inputs right after the reference word; they expose a block that samples late. Random input gaps and output back-pressure check that the word order and the held output survive stalls.

// File: rtl/lnpid_pkg.sv
package lnpid_pkg;
  localparam int WORD_W = 10;
  localparam int LINE_W = 11;
  localparam logic [7:0] DID_BYTE  = 8'h41;
  localparam logic [7:0] SDID_BYTE = 8'h01;

  // Ancillary word: byte with even parity bit and inverted parity on top.
  function automatic logic [WORD_W-1:0] anc_word(input logic [7:0] b);
    return {~(^b), ^b, b};
  endfunction

  function automatic logic [WORD_W-1:0] line_word0(input logic [LINE_W-1:0] l);
    return {~l[6], l[6:0], 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] line_word1(input logic [LINE_W-1:0] l);
    return {1'b1, 3'b000, l[10:7], 2'b00};
  endfunction
endpackage

// File: rtl/lnpid_stage.sv
module lnpid_stage #(
  parameter int W = 160
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (in_ready && in_valid) q <= d;
  end

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(q));

  // R3
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/lnpid_lane.sv
module lnpid_lane
  import lnpid_pkg::*;
#(
  parameter int PID_BYTES = 4,
  parameter int PKT_START = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire,
  input  logic [WORD_W-1:0]      in_w,
  input  logic [LINE_W-1:0]      ln_v,
  input  logic [8*PID_BYTES-1:0] pid_v,
  input  logic                   ln_req,
  input  logic                   pid_req,
  output logic [WORD_W-1:0]      out_w
);
  localparam int PKT_LEN = 7 + PID_BYTES;
  localparam int LAST    = PKT_START + PKT_LEN - 1;
  localparam int PW      = $clog2(LAST + 1);

  logic [WORD_W-1:0]      p1, p2, p3;
  logic [PW-1:0]          pos;
  logic [LINE_W-1:0]      ln_q;
  logic [8*PID_BYTES-1:0] pid_q;
  logic                   ln_on, pid_on;
  logic                   is_eav;
  logic [8:0]             csum;
  logic [WORD_W-1:0]      pkt_w;

  assign is_eav = (p3 == 10'h3FF) && (p2 == '0) && (p1 == '0) && in_w[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1 <= '0; p2 <= '0; p3 <= '0;
      pos <= '0; ln_q <= '0; pid_q <= '0;
      ln_on <= 1'b0; pid_on <= 1'b0;
    end else if (fire) begin
      p3 <= p2; p2 <= p1; p1 <= in_w;
      if (is_eav) begin
        pos    <= PW'(1);
        ln_q   <= ln_v;
        pid_q  <= pid_v;
        ln_on  <= ln_req;
        pid_on <= ln_req && pid_req;
      end else if (pos != '0) begin
        pos <= (pos == PW'(LAST)) ? '0 : pos + PW'(1);
      end
    end
  end

  always_comb begin
    csum = 9'(anc_word(DID_BYTE)) + 9'(anc_word(SDID_BYTE)) + 9'(anc_word(8'(PID_BYTES)));
    for (int b = 0; b < PID_BYTES; b++) csum = csum + 9'(anc_word(pid_q[8*b +: 8]));
  end

  always_comb begin
    int idx;
    int bsel;
    idx  = int'(pos) - PKT_START;
    bsel = (idx >= 6 && idx < 6 + PID_BYTES) ? idx - 6 : 0;
    if (idx == 0)                 pkt_w = 10'h000;
    else if (idx < 3)             pkt_w = 10'h3FF;
    else if (idx == 3)            pkt_w = anc_word(DID_BYTE);
    else if (idx == 4)            pkt_w = anc_word(SDID_BYTE);
    else if (idx == 5)            pkt_w = anc_word(8'(PID_BYTES));
    else if (idx < 6 + PID_BYTES) pkt_w = anc_word(pid_q[8*bsel +: 8]);
    else                          pkt_w = {~csum[8], csum};
  end

  always_comb begin
    out_w = in_w;
    if (ln_on && pos == PW'(1)) out_w = line_word0(ln_q);
    if (ln_on && pos == PW'(2)) out_w = line_word1(ln_q);
    if (pid_on && pos >= PW'(PKT_START)) out_w = pkt_w;
  end

  // R5
  ln_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ln_on && (pos == PW'(1) || pos == PW'(2)) |-> out_w[9] != out_w[8]);

  // R8
  crc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (pos == PW'(3) || pos == PW'(4)) |-> out_w == in_w);

  // R3
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !ln_on && !pid_on |-> out_w == in_w);
endmodule

// File: rtl/lnpid_inserter.sv
module lnpid_inserter
  import lnpid_pkg::*;
#(
  parameter int NPAIR     = 8,
  parameter int PID_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [2*NPAIR*WORD_W-1:0]    in_data,
  input  logic [NPAIR*LINE_W-1:0]      ln_in,
  input  logic [NPAIR*8*PID_BYTES-1:0] pid_in,
  input  logic [NPAIR*8*PID_BYTES-1:0] pidx_in,
  input  logic                         ins_ln,
  input  logic                         ins_pid,
  input  logic                         ins_x,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [2*NPAIR*WORD_W-1:0]    out_data
);
  localparam int NSTREAM = 2 * NPAIR;
  localparam int DW      = NSTREAM * WORD_W;
  localparam int PIDW    = 8 * PID_BYTES;

  logic          fire;
  logic [DW-1:0] lane_out;

  assign fire = in_valid && in_ready;

  for (genvar s = 0; s < NSTREAM; s++) begin : g_lane
    localparam int K = s / 2;
    logic [PIDW-1:0] pid_sel;
    logic            pid_go;
    if (s % 2 == 0) begin : g_odd
      assign pid_sel = pid_in[PIDW*K +: PIDW];
      assign pid_go  = ins_pid;
    end else begin : g_even
      assign pid_sel = pidx_in[PIDW*K +: PIDW];
      assign pid_go  = ins_pid && ins_x;
    end
    lnpid_lane #(.PID_BYTES(PID_BYTES)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire),
      .in_w   (in_data[WORD_W*s +: WORD_W]),
      .ln_v   (ln_in[LINE_W*K +: LINE_W]),
      .pid_v  (pid_sel),
      .ln_req (ins_ln),
      .pid_req(pid_go),
      .out_w  (lane_out[WORD_W*s +: WORD_W])
    );
  end

  lnpid_stage #(.W(DW)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .d        (lane_out),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .q        (out_data)
  );
endmodule

// File: tb/lnpid_inserter_tb.sv
module lnpid_inserter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPAIR = 8;
  localparam int NS = 16;
  localparam int DW = NS * 10;
  localparam int LINE_LEN = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic [87:0] ln_in = '0;
  logic [255:0] pid_in = '0;
  logic [255:0] pidx_in = '0;
  logic ins_ln = 1'b0, ins_pid = 1'b0, ins_x = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [DW-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  int bp = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lnpid_inserter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ln_in(ln_in), .pid_in(pid_in), .pidx_in(pidx_in),
    .ins_ln(ins_ln), .ins_pid(ins_pid), .ins_x(ins_x),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [9:0] src_word(int s, int i);
    case (i)
      2, 7:          return 10'h274;
      4, 27:         return 10'h3FF;
      5, 6, 28, 29:  return 10'h000;
      30:            return 10'h200;
      default:       return 10'h040 + 10'((s * 37 + i * 13) % 700);
    endcase
  endfunction

  function automatic logic [9:0] tb_udw(logic [7:0] b);
    return {~(^b), ^b, b};
  endfunction

  function automatic logic [9:0] tb_pkt(int idx, logic [31:0] p);
    logic [8:0] sm;
    sm = 9'h041 + 9'h101 + 9'h104;
    for (int j = 0; j < 4; j++) sm = sm + tb_udw(p[8*j +: 8])[8:0];
    case (idx)
      0: return 10'h000;
      1, 2: return 10'h3FF;
      3: return 10'h241;
      4: return 10'h101;
      5: return 10'h104;
      6, 7, 8, 9: return tb_udw(p[8*(idx-6) +: 8]);
      default: return {~sm[8], sm};
    endcase
  endfunction

  function automatic logic [9:0] exp_word(int s, int i, logic [87:0] l, logic [255:0] p,
                                          logic [255:0] px, bit cl, bit cp, bit cx);
    int pos;
    int k;
    logic [9:0] w;
    logic [10:0] lv;
    pos = (i >= 8 && i <= 22) ? i - 7 : 0;
    k = s / 2;
    lv = l[11*k +: 11];
    w = src_word(s, i);
    if (cl && pos == 1) w = {~lv[6], lv[6:0], 2'b00};
    if (cl && pos == 2) w = {1'b1, 3'b000, lv[10:7], 2'b00};
    if (cl && cp && pos >= 5 && (s % 2 == 0 || cx))
      w = tb_pkt(pos - 5, (s % 2 == 0) ? p[32*k +: 32] : px[32*k +: 32]);
    return w;
  endfunction

  task automatic send_line(string tag, logic [87:0] l, logic [255:0] p, logic [255:0] px,
                           bit cl, bit cp, bit cx, bit flip, int gap);
    for (int i = 0; i < LINE_LEN; i++) begin
      logic [DW-1:0] d;
      logic [DW-1:0] e;
      for (int s = 0; s < NS; s++) begin
        d[10*s +: 10] = src_word(s, i);
        e[10*s +: 10] = exp_word(s, i, l, p, px, cl, cp, cx);
      end
      @(negedge clk);
      if (i == 0) begin
        ln_in = l; pid_in = p; pidx_in = px;
        ins_ln = cl; ins_pid = cp; ins_x = cx;
      end
      if (flip && i == 8) begin
        ln_in = ~l; pid_in = ~p; pidx_in = ~px;
        ins_ln = !cl; ins_pid = !cp; ins_x = !cx;
      end
      while ($urandom_range(99) < gap) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data = d;
      while (!in_ready) @(negedge clk);
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Back-pressure source
  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = ($urandom_range(99) >= bp);
    end
  end

  // Monitor / scoreboard
  initial begin
    bit stalled;
    logic [DW-1:0] held;
    stalled = 0;
    held = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stalled) begin
          n_chk++;
          if (!(out_valid && out_data == held)) begin
            n_fail++;
            $display("FAIL R2 held output: got valid=%0b data=%h exp valid=1 data=%h",
                     out_valid, out_data, held);
          end
        end
        stalled = out_valid && !out_ready;
        held = out_data;
        if (out_valid && out_ready) begin
          n_chk++;
          if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R3 extra output word: got %h exp none", out_data);
          end else begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (out_data !== e) begin
              n_fail++;
              $display("FAIL %s: got %h exp %h", t, out_data, e);
            end
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [87:0] lna, lnb;
    logic [255:0] pa, pb;
    for (int k = 0; k < NPAIR; k++) begin
      lna[11*k +: 11] = 11'h400 + 11'(k * 97 + 3);
      lnb[11*k +: 11] = 11'h7FF - 11'(k * 131);
      pa[32*k +: 32] = 32'hA5C3_0F81 ^ (32'h0101_0101 * 32'(k));
      pb[32*k +: 32] = 32'h3C96_E712 + (32'h1111_0203 * 32'(k));
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset: got valid=%0b ready=%0b exp valid=0 ready=1", out_valid, in_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;

    send_line("R3/R4 passthrough", lna, pa, pb, 0, 0, 0, 0, 0);
    send_line("R5/R6/R8 line numbers A", lna, pa, pb, 1, 0, 0, 0, 0);
    send_line("R5/R6 line numbers B", lnb, pa, pb, 1, 0, 0, 0, 10);
    send_line("R9/R10 odd-stream packet", lna, pa, pb, 1, 1, 0, 0, 0);
    send_line("R11 packet without line enable", lna, pa, pb, 0, 1, 1, 0, 0);
    bp = 40;
    send_line("R12 packets in both streams", lnb, pb, pa, 1, 1, 1, 0, 30);
    send_line("R2/R9/R10 stalled packet", lna, pb, pa, 1, 1, 0, 0, 20);
    send_line("R7/R13 inputs changed after reference", lna, pa, pb, 1, 1, 1, 1, 10);
    send_line("R13 enable raised after reference", lnb, pa, pb, 0, 1, 1, 1, 0);
    bp = 0;
    send_line("R3/R4 passthrough tail", lnb, pb, pa, 0, 0, 0, 0, 0);

    for (int w = 0; w < 1000 && exp_q.size() != 0; w++) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R3 missing output words: got %0d pending exp 0", exp_q.size());
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule